// File: doc/BRIEF.md
# PLL Control Register and Lock-Change Interrupt Block

This block holds the software-visible controls for a clock-generation PLL and sits on a simple byte-wide bus. The bus has separate write and read strobes, a two-bit register address and read data that is registered. The control register carries five bits: one switches the PLL on, one selects the PLL output as the base clock, one turns on automatic mode, one enables the interrupt, and one is a sticky interrupt flag. Two further registers hold a VCO range code and a 4-bit reference divider code. While the PLL runs, the block keeps both codes from changing. It also refuses to select the PLL clock while the VCO range code is all zero.

The lock indication arrives as a plain asynchronous input. It passes through a synchroniser, and any change of the synchronised level is an edge event. In automatic mode every edge event sets the interrupt flag, whether the PLL enters or leaves lock. The interrupt line is the flag gated by the enable bit. Software reads the lock level from the control register to find out which of the two transitions happened. A modulo counter turns the divider code into a one-cycle reference pulse.

Top module: `pll_ctl_block`

## Requirements
- R1: While the automatic-mode bit (control bit 2) is 1, every change of `lock_in`, rising or falling, sets the interrupt flag (control bit 4). The flag is visible no later than four clocks after the input changes, because the input first crosses a two-flop synchroniser.
- R2: The flag is set whatever the value of the interrupt-enable bit (control bit 3). `irq_o` is high exactly when the flag and the enable bit are both 1.
- R3: While the automatic-mode bit is 0, the flag reads 0 and `irq_o` stays 0, even when `lock_in` changes.
- R4: While the PLL-on bit (control bit 0) is 1, a write to the reference divider register (address 2) leaves its value unchanged.
- R5: While the PLL-on bit is 1, `ref_pulse_o` is high for one clock in every R clocks. R is the divider code, and a code of 0 gives R = 1. While the PLL-on bit is 0, `ref_pulse_o` stays 0.
- R6: After reset the control register and the VCO range register (address 1) read 0. The divider register reads 0x01, and its upper four bits always read 0.
- R7: While the PLL-on bit is 1, a write to the VCO range register leaves its value unchanged.
- R8: A control write with the base-clock-select bit (control bit 1) at 1 leaves that bit unchanged while the VCO range register is all zero. Once the range register is nonzero the same write sets it, and `bcs_o` follows the bit.
- R9: Control bit 5 reads the synchronised lock level, and writes to it are ignored.
- R10: Reading never clears the flag. Writing 1 to control bit 4 clears it. If a lock change is detected in the same clock as that write, the flag stays set.
- R11: `bus_rdata` shows the register addressed in a clock with `bus_rd` high from the next clock onward. Address 3 reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 VCO range, 2 divider |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| lock_in | input | 1 | Asynchronous lock indication from the PLL |
| pll_on_o | output | 1 | PLL-on bit |
| bcs_o | output | 1 | Base-clock-select bit |
| vco_sel_o | output | VCO_W | VCO range code |
| ref_pulse_o | output | 1 | Reference divider pulse |
| irq_o | output | 1 | Lock-change interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus and an 8-bit VCO range field, so a range value of all zero is one code among 256 and random writes hit it only when steered there. With a 4-bit divider field, all sixteen divider codes can be swept one by one, so the gap between pulses is measured for each code, including the zero code. A two-stage synchroniser gives a fixed edge-to-flag latency, and that latency is what lets the bench place a flag-clearing write in exactly the same clock as a detected lock change.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_VCO  = 2'd1,
    ADR_RDIV = 2'd2,
    ADR_NONE = 2'd3
  } reg_addr_e;

  localparam int unsigned CB_ON   = 0;
  localparam int unsigned CB_BCS  = 1;
  localparam int unsigned CB_AUTO = 2;
  localparam int unsigned CB_IE   = 3;
  localparam int unsigned CB_FLAG = 4;
  localparam int unsigned CB_LOCK = 5;

  typedef struct packed {
    logic ie;
    logic auto_m;
    logic bcs;
    logic on;
  } ctrl_bits_t;
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_in,
  output logic lock_s,
  output logic lock_chg
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain_q;
  logic         prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[N-2:0], lock_in};
      prev_q  <= chain_q[N-1];
    end
  end

  assign lock_s   = chain_q[N-1];
  assign lock_chg = chain_q[N-1] ^ prev_q;

  AST_CHG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    lock_chg |=> (prev_q == $past(lock_s))); // R1
endmodule

// File: rtl/pll_ref_div.sv
module pll_ref_div #(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             pulse
);
  logic [SEL_W-1:0] cnt_q;
  logic [SEL_W-1:0] last_cnt;
  logic             pulse_q;

  assign last_cnt = (sel == '0) ? '0 : (sel - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= (cnt_q == last_cnt);
      cnt_q   <= (cnt_q >= last_cnt) ? '0 : (cnt_q + 1'b1);
    end
  end

  assign pulse = pulse_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (pulse_q && run && $stable(sel) && sel > 1) |=> !pulse_q); // R5
  AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pulse_q); // R5
endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
  import pll_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned VCO_W  = 8,
  parameter int unsigned RDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  reg_addr_e         addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lock_chg,
  output ctrl_bits_t        ctrl,
  output logic              flag,
  output logic [VCO_W-1:0]  vco,
  output logic [RDIV_W-1:0] rdiv
);
  localparam logic [RDIV_W-1:0] RDIV_RST = {{(RDIV_W-1){1'b0}}, 1'b1};

  ctrl_bits_t        ctrl_q, ctrl_n;
  logic              flag_q, flag_n;
  logic [VCO_W-1:0]  vco_q, vco_n;
  logic [RDIV_W-1:0] rdiv_q, rdiv_n;
  logic              wr_ctrl, wr_vco, wr_rdiv;
  logic              set_ev, clr_ev;
  logic              unused_wdata;

  assign wr_ctrl = wr && (addr == ADR_CTRL);
  assign wr_vco  = wr && (addr == ADR_VCO);
  assign wr_rdiv = wr && (addr == ADR_RDIV);
  assign unused_wdata = ^wdata;

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_ctrl) begin
      ctrl_n.on     = wdata[CB_ON];
      ctrl_n.auto_m = wdata[CB_AUTO];
      ctrl_n.ie     = wdata[CB_IE];
      if (!(wdata[CB_BCS] && (vco_q == '0))) ctrl_n.bcs = wdata[CB_BCS];
    end
  end

  always_comb begin
    vco_n  = (wr_vco  && !ctrl_q.on) ? wdata[VCO_W-1:0]  : vco_q;
    rdiv_n = (wr_rdiv && !ctrl_q.on) ? wdata[RDIV_W-1:0] : rdiv_q;
  end

  assign set_ev = ctrl_q.auto_m && lock_chg;
  assign clr_ev = wr_ctrl && wdata[CB_FLAG];

  always_comb begin
    if (!ctrl_n.auto_m)  flag_n = 1'b0;
    else if (set_ev)     flag_n = 1'b1;
    else if (clr_ev)     flag_n = 1'b0;
    else                 flag_n = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      vco_q  <= '0;
      rdiv_q <= RDIV_RST;
    end else begin
      ctrl_q <= ctrl_n;
      flag_q <= flag_n;
      vco_q  <= vco_n;
      rdiv_q <= rdiv_n;
    end
  end

  assign ctrl = ctrl_q;
  assign flag = flag_q;
  assign vco  = vco_q;
  assign rdiv = rdiv_q;

  AST_RDIV_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (wr_rdiv && ctrl_q.on) |=> $stable(rdiv_q)); // R4
  AST_VCO_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (wr_vco && ctrl_q.on) |=> $stable(vco_q)); // R7
  AST_BCS_GUARD: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wdata[CB_BCS] && (vco_q == '0) && !ctrl_q.bcs) |=> !ctrl_q.bcs); // R8
  AST_FLAG_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (lock_chg && ctrl_q.auto_m && !(wr_ctrl && !wdata[CB_AUTO])) |=> flag_q); // R1
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !wr_ctrl) |=> flag_q); // R10
  AST_FLAG_NOAUTO: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.auto_m |-> !flag_q); // R3
endmodule

// File: rtl/pll_ctl_block.sv
module pll_ctl_block
  import pll_ctl_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned VCO_W       = 8,
  parameter int unsigned RDIV_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              lock_in,
  output logic              pll_on_o,
  output logic              bcs_o,
  output logic [VCO_W-1:0]  vco_sel_o,
  output logic              ref_pulse_o,
  output logic              irq_o
);
  reg_addr_e         addr_e;
  ctrl_bits_t        ctrl;
  logic              flag;
  logic [VCO_W-1:0]  vco;
  logic [RDIV_W-1:0] rdiv;
  logic              lock_s, lock_chg;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign addr_e = reg_addr_e'(bus_addr);

  pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .lock_in  (lock_in),
    .lock_s   (lock_s),
    .lock_chg (lock_chg)
  );

  pll_ctl_regs #(.DATA_W(DATA_W), .VCO_W(VCO_W), .RDIV_W(RDIV_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .addr     (addr_e),
    .wdata    (bus_wdata),
    .lock_chg (lock_chg),
    .ctrl     (ctrl),
    .flag     (flag),
    .vco      (vco),
    .rdiv     (rdiv)
  );

  pll_ref_div #(.SEL_W(RDIV_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .run   (ctrl.on),
    .sel   (rdiv),
    .pulse (ref_pulse_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (addr_e)
      ADR_CTRL: begin
        rd_mux[CB_ON]   = ctrl.on;
        rd_mux[CB_BCS]  = ctrl.bcs;
        rd_mux[CB_AUTO] = ctrl.auto_m;
        rd_mux[CB_IE]   = ctrl.ie;
        rd_mux[CB_FLAG] = flag;
        rd_mux[CB_LOCK] = lock_s;
      end
      ADR_VCO:  rd_mux[VCO_W-1:0]  = vco;
      ADR_RDIV: rd_mux[RDIV_W-1:0] = rdiv;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign pll_on_o  = ctrl.on;
  assign bcs_o     = ctrl.bcs;
  assign vco_sel_o = vco;
  assign irq_o     = flag & ctrl.ie;

  AST_IRQ_NOAUTO: assert property (@(posedge clk) disable iff (rst)
    !ctrl.auto_m |-> !irq_o); // R3
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ctrl.ie); // R2
  AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && addr_e == ADR_NONE) |=> (bus_rdata == '0)); // R11
  AST_RDIV_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && addr_e == ADR_RDIV) |=> (bus_rdata[DATA_W-1:RDIV_W] == '0)); // R6
endmodule

// File: tb/pll_ctl_block_tb.sv
`timescale 1ns/1ps
module pll_ctl_block_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       lock_in = 1'b0;
  logic       pll_on_o, bcs_o, ref_pulse_o, irq_o;
  logic [7:0] vco_sel_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic       m_on, m_bcs, m_auto, m_ie, m_flag, m_lock;
  logic [7:0] m_vco;
  logic [3:0] m_rdiv;

  always #4 clk = ~clk;

  pll_ctl_block dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_in(lock_in),
    .pll_on_o(pll_on_o), .bcs_o(bcs_o), .vco_sel_o(vco_sel_o),
    .ref_pulse_o(ref_pulse_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_on = 0; m_bcs = 0; m_auto = 0; m_ie = 0; m_flag = 0;
    m_vco = 8'h00; m_rdiv = 4'h1; m_lock = lock_in;
  endtask

  function automatic logic [7:0] ctl_word(logic on, logic bcs, logic au, logic ie, logic fl);
    return {3'b000, fl, ie, au, bcs, on};
  endfunction

  function automatic logic [7:0] exp_read(logic [1:0] a);
    case (a)
      2'd0:    return {2'b00, m_lock, m_flag, m_ie, m_auto, m_bcs, m_on};
      2'd1:    return m_vco;
      2'd2:    return {4'b0000, m_rdiv};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: begin
        m_on = d[0]; m_auto = d[2]; m_ie = d[3];
        if (!(d[1] && m_vco == 8'h00)) m_bcs = d[1];
        if (d[4]) m_flag = 1'b0;
        if (!m_auto) m_flag = 1'b0;
      end
      2'd1: if (!m_on) m_vco = d;
      2'd2: if (!m_on) m_rdiv = d[3:0];
      default: ;
    endcase
  endtask

  task automatic set_lock(input logic v);
    @(negedge clk);
    lock_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED1234));
    do_reset();

    // R6 / R11: reset values and unmapped address
    chk("R6 reset ctrl out", {30'd0, pll_on_o, bcs_o}, 32'd0);
    rd(2'd0, d); chk("R6 ctrl reset", d, 8'h00);
    rd(2'd1, d); chk("R6 vco reset", d, 8'h00);
    rd(2'd2, d); chk("R6 rdiv reset", d, 8'h01);
    wr(2'd3, 8'hFF);
    rd(2'd3, d); chk("R11 unmapped", d, 8'h00);
    chk("R11 unmapped write no effect", {24'd0, vco_sel_o}, 32'd0);

    // R3 / R9: lock change with automatic mode off
    set_lock(1'b1);
    rd(2'd0, d);
    chk("R9 lock level", d[5], 1);
    chk("R3 flag stays 0", d[4], 0);
    chk("R3 irq off", irq_o, 0);

    // R1 / R2: exit from lock with interrupt disabled
    wr(2'd0, ctl_word(0, 0, 1, 0, 0));
    set_lock(1'b0);
    rd(2'd0, d);
    chk("R1 flag on exit", d[4], 1);
    chk("R9 lock low", d[5], 0);
    chk("R2 irq gated", irq_o, 0);
    wr(2'd0, ctl_word(0, 0, 1, 1, 0));
    chk("R2 irq raised", irq_o, 1);
    // R10: reads do not clear
    rd(2'd0, d); rd(2'd0, d);
    chk("R10 read keeps flag", d[4], 1);
    wr(2'd0, ctl_word(0, 0, 1, 1, 1));
    rd(2'd0, d);
    chk("R10 w1c clears", d[4], 0);
    chk("R10 irq drops", irq_o, 0);
    // R1: entry into lock
    set_lock(1'b1);
    rd(2'd0, d);
    chk("R1 flag on entry", d[4], 1);
    chk("R9 lock high", d[5], 1);
    // R10: clear in same clock as detected change
    @(negedge clk); lock_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = ctl_word(0, 0, 1, 1, 1);
    @(negedge clk); bus_wr = 1'b0;
    rd(2'd0, d);
    chk("R10 change beats clear", d[4], 1);
    // R3: leaving automatic mode
    wr(2'd0, ctl_word(0, 0, 0, 1, 0));
    rd(2'd0, d);
    chk("R3 flag cleared by auto off", d[4], 0);
    chk("R3 irq off again", irq_o, 0);
    set_lock(1'b1);
    rd(2'd0, d);
    chk("R3 change ignored", d[4], 0);

    // R8: base-clock select guarded by zero VCO range
    wr(2'd0, ctl_word(0, 1, 0, 0, 0));
    chk("R8 bcs blocked", bcs_o, 0);
    wr(2'd1, 8'h40);
    wr(2'd0, ctl_word(0, 1, 0, 0, 0));
    chk("R8 bcs allowed", bcs_o, 1);

    // R4 / R7: protection while PLL on
    wr(2'd2, 8'h03);
    wr(2'd0, ctl_word(1, 1, 0, 0, 0));
    wr(2'd2, 8'h07);
    rd(2'd2, d); chk("R4 rdiv frozen", d, 8'h03);
    wr(2'd1, 8'h11);
    rd(2'd1, d); chk("R7 vco frozen", d, 8'h40);
    chk("R7 vco port frozen", {24'd0, vco_sel_o}, 32'h40);
    wr(2'd0, 8'h00);

    // R5: divider sweep over all codes
    for (int c = 0; c < 16; c++) begin
      int gap;
      int g;
      int r_exp;
      r_exp = (c == 0) ? 1 : c;
      wr(2'd2, 8'(c));
      wr(2'd0, ctl_word(1, 0, 0, 0, 0));
      g = 0;
      while (!ref_pulse_o && g < 40) begin @(negedge clk); g++; end
      gap = 0;
      do begin @(negedge clk); gap++; end while (!ref_pulse_o && gap < 40);
      chk($sformatf("R5 gap code %0d", c), gap, r_exp);
      wr(2'd0, 8'h00);
      g = 0;
      repeat (20) begin @(negedge clk); if (ref_pulse_o) g++; end
      chk("R5 idle when off", g, 0);
    end

    // Random register traffic against the bench model
    do_reset();
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      logic [7:0] v;
      string tag;
      a = 2'($urandom_range(0, 3));
      v = 8'($urandom);
      if (a == 2'd1 && $urandom_range(0, 3) == 0) v = 8'h00;
      if (a == 2'd0 && $urandom_range(0, 2) == 0) v[0] = 1'b0;
      wr(a, v);
      model_write(a, v);
      case (a)
        2'd0: tag = "R8";
        2'd1: tag = "R7";
        2'd2: tag = "R4";
        default: tag = "R11";
      endcase
      rd(a, d);
      chk(tag, d, exp_read(a));
      chk("R8 bcs port", bcs_o, m_bcs);
      chk("R2 irq port", irq_o, m_flag & m_ie);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule